// File: doc/BRIEF.md
# Scoreboard Issue Hazard Controller

This block is the central hazard controller for a small out-of-order execution cluster. There are five execution slots: one integer slot, two floating-point multiply slots, one floating-point add slot and one floating-point divide slot. Decoded instructions arrive one at a time in program order. Each instruction carries an operation class, a destination register and two source registers. The controller either accepts the instruction into a free slot of the right class or holds it back. A stalled instruction blocks every instruction behind it.

For each slot the controller keeps one entry. The entry holds a busy mark, the register numbers, the tag of the slot that will produce each source, and a flag per source that means "value present but not yet read". A register-status table names, for each register, the slot that will write it, or tag 0 when no slot will. The controller pulses a per-slot operand-read grant when both sources are present. It counts the slot's execution latency itself and then pulses a per-slot write-back grant once no earlier instruction still has to read the old contents of the destination. The datapath, the register file and any forwarding are outside this block.

The instruction input is a valid/ready stream. `in_ready` depends only on the controller state and `in_class`/`in_dst`, never on `in_valid`. An instruction is taken on a rising edge where both are high. While `in_valid` is high and `in_ready` is low, the source must hold every field stable and must not present a later instruction.

Top module: `sb_ctrl`

## Requirements
- R1: After reset no slot is busy, no read or write-back grant is raised, and `in_ready` is high for any class.
- R2: Slot tags are integer=1, multiply A=2, multiply B=3, add=4, divide=5. Tag 0 means none. Class codes are 0 integer, 1 multiply, 2 add, 3 divide. A multiply goes to slot 2 when that slot is free, and to slot 3 otherwise. `in_unit` shows the chosen tag while `in_ready` is high.
- R3: When every slot of the instruction's class is busy, `in_ready` stays low until one of them frees.
- R4: When a busy slot already targets the instruction's destination register, `in_ready` stays low.
- R5: A source that a busy slot is still producing is not read until that slot's write-back grant. The read grant comes in the cycle after the write-back grant. This also holds when the consumer is accepted in the same cycle as the producer's write-back grant.
- R6: An instruction whose sources have no pending producer gets its read grant in the cycle right after the edge that accepts it.
- R7: With no WAR conflict, the write-back grant comes LAT+1 cycles after the read grant, where LAT is the slot's latency parameter.
- R8: A finished slot's write-back grant is withheld while another busy slot holds an unread source equal to the finished slot's destination. The grant is given in the cycle after that reader's read grant.
- R9: A slot is free in the cycle after its write-back grant. An instruction held by R3 or R4 sees `in_ready` high in that cycle.
- R10: Every accepted instruction produces exactly one read grant and exactly one write-back grant on its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_class | input | 2 | Operation class (0 int, 1 mul, 2 add, 3 div) |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| in_unit | output | 3 | Tag of the slot the instruction would take, 0 if none |
| unit_busy | output | 5 | Per-slot busy, bit i is tag i+1 |
| rd_go | output | 5 | Per-slot operand-read grant pulse |
| wb_go | output | 5 | Per-slot write-back grant pulse |

## Verification
The bench builds the controller with latencies of 1 (integer), 2 (add), 4 (multiply) and 8 (divide) in place of the long defaults. This keeps every hazard window to a few cycles, so the exact grant cycles can be checked. A slow divide with a quick integer slot makes it possible to finish a writer before its reader and so exercise the WAR hold. The gap between an integer producer and an add consumer lets the consumer be accepted on the very cycle of the producer's write-back, which exercises the same-cycle tag bypass.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_UNITS = 5;
  localparam int TAG_W     = 3;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_MUL = 2'd1,
    CLS_ADD = 2'd2,
    CLS_DIV = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_RD,
    ST_EXEC,
    ST_DONE
  } unit_st_e;
endpackage

// File: rtl/sb_issue.sv
module sb_issue
  import sb_pkg::*;
(
  input  logic [1:0]           cls,
  input  logic [NUM_UNITS-1:0] busy,
  output logic [TAG_W-1:0]     sel_tag
);
  always_comb begin
    sel_tag = '0;
    unique case (op_class_e'(cls))
      CLS_INT: if (!busy[0]) sel_tag = 3'd1;
      CLS_MUL: begin
        if (!busy[1])      sel_tag = 3'd2;
        else if (!busy[2]) sel_tag = 3'd3;
      end
      CLS_ADD: if (!busy[3]) sel_tag = 3'd4;
      CLS_DIV: if (!busy[4]) sel_tag = 3'd5;
      default: sel_tag = '0;
    endcase
  end
endmodule

// File: rtl/sb_regstat.sv
module sb_regstat
  import sb_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            set_en,
  input  logic [REG_W-1:0]                set_reg,
  input  logic [TAG_W-1:0]                set_tag,
  input  logic [NUM_UNITS-1:0]            clr,
  input  logic [NUM_UNITS-1:0][REG_W-1:0] clr_reg,
  input  logic [REG_W-1:0]                rd_a,
  input  logic [REG_W-1:0]                rd_b,
  input  logic [REG_W-1:0]                rd_c,
  output logic [TAG_W-1:0]                tag_a,
  output logic [TAG_W-1:0]                tag_b,
  output logic [TAG_W-1:0]                tag_c
);
  localparam int NREG = 1 << REG_W;

  logic [TAG_W-1:0] status   [NREG];
  logic [TAG_W-1:0] status_n [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      status_n[r] = status[r];
      for (int u = 0; u < NUM_UNITS; u++)
        if (clr[u] && clr_reg[u] == REG_W'(r) && status[r] == TAG_W'(u + 1))
          status_n[r] = '0;
    end
    if (set_en) status_n[set_reg] = set_tag;
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++)
      status[r] <= rst_n ? status_n[r] : '0;
  end

  assign tag_a = status[rd_a];
  assign tag_b = status[rd_b];
  assign tag_c = status[rd_c];

  // R4
  mark_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> status[$past(set_reg)] == $past(set_tag));
endmodule

// File: rtl/sb_unit.sv
module sb_unit
  import sb_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int LAT   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [REG_W-1:0]     fi_in,
  input  logic [REG_W-1:0]     fj_in,
  input  logic [REG_W-1:0]     fk_in,
  input  logic [TAG_W-1:0]     qj_in,
  input  logic [TAG_W-1:0]     qk_in,
  input  logic [NUM_UNITS-1:0] wb_all,
  input  logic                 war_ok,
  output logic                 busy,
  output logic                 rd_go,
  output logic                 wb_go,
  output logic [REG_W-1:0]     fi,
  output logic [REG_W-1:0]     fj,
  output logic [REG_W-1:0]     fk,
  output logic                 rj,
  output logic                 rk
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  unit_st_e         st;
  logic [CW-1:0]    cnt;
  logic [TAG_W-1:0] qj, qk;
  logic             hit_j, hit_k;

  always_comb begin
    hit_j = 1'b0;
    hit_k = 1'b0;
    for (int w = 0; w < NUM_UNITS; w++) begin
      if (wb_all[w] && qj == TAG_W'(w + 1)) hit_j = 1'b1;
      if (wb_all[w] && qk == TAG_W'(w + 1)) hit_k = 1'b1;
    end
  end

  assign busy  = (st != ST_IDLE);
  assign rd_go = (st == ST_WAIT_RD) && rj && rk;
  assign wb_go = (st == ST_DONE) && war_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      qj  <= '0;
      qk  <= '0;
      rj  <= 1'b0;
      rk  <= 1'b0;
      fi  <= '0;
      fj  <= '0;
      fk  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (take) begin
          st <= ST_WAIT_RD;
          fi <= fi_in;
          fj <= fj_in;
          fk <= fk_in;
          qj <= qj_in;
          qk <= qk_in;
          rj <= (qj_in == '0);
          rk <= (qk_in == '0);
        end
        ST_WAIT_RD: begin
          if (rd_go) begin
            st  <= ST_EXEC;
            cnt <= CW'(LAT - 1);
            rj  <= 1'b0;
            rk  <= 1'b0;
          end else begin
            if (hit_j) begin qj <= '0; rj <= 1'b1; end
            if (hit_k) begin qk <= '0; rk <= 1'b1; end
          end
        end
        ST_EXEC: begin
          if (cnt == '0) st <= ST_DONE;
          else           cnt <= cnt - 1'b1;
        end
        ST_DONE: if (war_ok) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6
  indep_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && qj_in == '0 && qk_in == '0) |=> rd_go);
  // R10
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_go);
  // R9
  free_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_go |=> !busy);
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_class,
  input  logic [REG_W-1:0]     in_dst,
  input  logic [REG_W-1:0]     in_src1,
  input  logic [REG_W-1:0]     in_src2,
  output logic [TAG_W-1:0]     in_unit,
  output logic [NUM_UNITS-1:0] unit_busy,
  output logic [NUM_UNITS-1:0] rd_go,
  output logic [NUM_UNITS-1:0] wb_go
);
  localparam int NU = NUM_UNITS;

  logic [TAG_W-1:0]         sel_tag, tag_s1, tag_s2, tag_d, qj_new, qk_new;
  logic [NU-1:0]            take, rj, rk, war_ok;
  logic [NU-1:0][REG_W-1:0] fi, fj, fk;
  logic                     fire;

  function automatic logic [TAG_W-1:0] bypass(input logic [TAG_W-1:0] t,
                                              input logic [NU-1:0] wb);
    bypass = t;
    for (int w = 0; w < NU; w++)
      if (wb[w] && t == TAG_W'(w + 1)) bypass = '0;
  endfunction

  sb_issue u_issue (
    .cls     (in_class),
    .busy    (unit_busy),
    .sel_tag (sel_tag)
  );

  sb_regstat #(.REG_W(REG_W)) u_regstat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (fire),
    .set_reg (in_dst),
    .set_tag (sel_tag),
    .clr     (wb_go),
    .clr_reg (fi),
    .rd_a    (in_src1),
    .rd_b    (in_src2),
    .rd_c    (in_dst),
    .tag_a   (tag_s1),
    .tag_b   (tag_s2),
    .tag_c   (tag_d)
  );

  assign in_unit  = sel_tag;
  assign in_ready = (sel_tag != '0) && (tag_d == '0);
  assign fire     = in_valid && in_ready;
  assign qj_new   = bypass(tag_s1, wb_go);
  assign qk_new   = bypass(tag_s2, wb_go);

  always_comb begin
    for (int u = 0; u < NU; u++)
      take[u] = fire && (sel_tag == TAG_W'(u + 1));
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    localparam int UL = (u == 0) ? LAT_INT :
                        (u == 3) ? LAT_ADD :
                        (u == 4) ? LAT_DIV : LAT_MUL;

    always_comb begin
      war_ok[u] = 1'b1;
      for (int f = 0; f < NU; f++)
        if (f != u)
          if ((rj[f] && fj[f] == fi[u]) || (rk[f] && fk[f] == fi[u]))
            war_ok[u] = 1'b0;
    end

    sb_unit #(.REG_W(REG_W), .LAT(UL)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take[u]),
      .fi_in  (in_dst),
      .fj_in  (in_src1),
      .fk_in  (in_src2),
      .qj_in  (qj_new),
      .qk_in  (qk_new),
      .wb_all (wb_go),
      .war_ok (war_ok[u]),
      .busy   (unit_busy[u]),
      .rd_go  (rd_go[u]),
      .wb_go  (wb_go[u]),
      .fi     (fi[u]),
      .fj     (fj[u]),
      .fk     (fk[u]),
      .rj     (rj[u]),
      .rk     (rk[u])
    );
  end

  // R2
  one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
  // R3
  take_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|take) |=> ((unit_busy & $past(take)) == $past(take)));
endmodule

// File: tb/test_sb_ctrl.sv
module test_sb_ctrl;
  localparam int REG_W = 5;
  localparam int L_INT = 1, L_ADD = 2, L_MUL = 4, L_DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_class = 2'd0;
  logic [REG_W-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [2:0] in_unit;
  logic [4:0] unit_busy, rd_go, wb_go;

  int cyc = 0, n_chk = 0, n_err = 0;
  int last_rd[5], last_wb[5], rd_cnt[5], wb_cnt[5], iss_cnt[5];

  always #5 clk = ~clk;

  sb_ctrl #(.REG_W(REG_W), .LAT_INT(L_INT), .LAT_ADD(L_ADD),
            .LAT_MUL(L_MUL), .LAT_DIV(L_DIV)) i_sb_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_unit(in_unit), .unit_busy(unit_busy), .rd_go(rd_go), .wb_go(wb_go));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int u = 0; u < 5; u++) begin
      if (rd_go[u]) begin last_rd[u] = cyc; rd_cnt[u]++; end
      if (wb_go[u]) begin last_wb[u] = cyc; wb_cnt[u]++; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  task automatic issue(input logic [1:0] cls, input int dst, input int s1, input int s2,
                       input int gap, input int exp_tag, input string req,
                       output int rdy_cyc, output int waited);
    @(negedge clk);
    repeat (gap) @(negedge clk);
    in_class = cls; in_dst = REG_W'(dst); in_src1 = REG_W'(s1); in_src2 = REG_W'(s2);
    in_valid = 1'b1;
    waited = 0;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
      waited++;
    end
    rdy_cyc = cyc;
    chk(req, int'(in_unit), exp_tag);
    if (exp_tag > 0) iss_cnt[exp_tag-1]++;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (unit_busy != 5'd0) @(negedge clk);
  endtask

  task automatic t_reset();
    in_class = 2'd2;
    #1;
    chk("R1 ready", int'(in_ready), 1);
    chk("R1 busy", int'(unit_busy), 0);
    chk("R1 rd_go", int'(rd_go), 0);
    chk("R1 wb_go", int'(wb_go), 0);
  endtask

  task automatic t_single(input logic [1:0] cls, input int tag, input int lat);
    int r, w;
    issue(cls, 20 + tag, 1, 2, 0, tag, "R2 tag", r, w);
    @(negedge clk);
    while (!wb_go[tag-1]) @(negedge clk);
    @(negedge clk);
    chk("R9 free after wb", int'(unit_busy[tag-1]), 0);
    chk("R6 read cycle", last_rd[tag-1], r + 1);
    chk("R7 wb cycle", last_wb[tag-1], last_rd[tag-1] + lat + 1);
  endtask

  task automatic t_mul_pair();
    int r, w;
    issue(2'd1, 3, 1, 2, 0, 2, "R2 mul A", r, w);
    issue(2'd1, 4, 1, 2, 0, 3, "R2 mul B", r, w);
    issue(2'd1, 5, 1, 2, 0, 2, "R2 mul C reuse", r, w);
    chk("R3 stalled", int'(w > 0), 1);
    chk("R9 ready after wb", r, last_wb[1] + 1);
    wait_idle();
  endtask

  task automatic t_waw();
    int r, w;
    issue(2'd3, 9, 1, 2, 0, 5, "R2 div", r, w);
    issue(2'd2, 9, 3, 4, 0, 4, "R2 add", r, w);
    chk("R4 stalled", int'(w > 0), 1);
    chk("R9 ready after wb", r, last_wb[4] + 1);
    wait_idle();
  endtask

  task automatic t_raw();
    int r, rb, w;
    issue(2'd1, 6, 1, 2, 0, 2, "R2 mul", r, w);
    issue(2'd2, 7, 6, 3, 0, 4, "R2 add", rb, w);
    wait_idle();
    chk("R5 read after producer", last_rd[3], last_wb[1] + 1);
    chk("R5 read withheld", int'(last_rd[3] > rb + 1), 1);
  endtask

  task automatic t_bypass();
    int r, w;
    issue(2'd0, 12, 1, 2, 0, 1, "R2 int", r, w);
    issue(2'd2, 13, 12, 12, 2, 4, "R2 add", r, w);
    wait_idle();
    chk("R5 same-cycle wb", last_rd[3], last_wb[0] + 1);
  endtask

  task automatic t_war();
    int r, ri, w;
    issue(2'd3, 0, 2, 4, 0, 5, "R2 div", r, w);
    issue(2'd2, 6, 0, 8, 0, 4, "R2 add", r, w);
    issue(2'd0, 8, 10, 11, 0, 1, "R2 int", ri, w);
    wait_idle();
    chk("R6 int read", last_rd[0], ri + 1);
    chk("R5 add read", last_rd[3], last_wb[4] + 1);
    chk("R8 wb held", last_wb[0], last_rd[3] + 1);
    chk("R8 wb late", int'(last_wb[0] > last_rd[0] + L_INT + 1), 1);
  endtask

  task automatic t_counts();
    for (int u = 0; u < 5; u++) begin
      chk("R10 reads", rd_cnt[u], iss_cnt[u]);
      chk("R10 writebacks", wb_cnt[u], iss_cnt[u]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    for (int u = 0; u < 5; u++) begin
      last_rd[u] = 0; last_wb[u] = 0; rd_cnt[u] = 0; wb_cnt[u] = 0; iss_cnt[u] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(2'd0, 1, L_INT);
    t_single(2'd2, 4, L_ADD);
    t_single(2'd1, 2, L_MUL);
    t_single(2'd3, 5, L_DIV);
    t_mul_pair();
    t_waw();
    t_raw();
    t_bypass();
    t_war();
    repeat (2) @(negedge clk);
    t_counts();
    summary();
  end
endmodule